// File: doc/BRIEF.md
# Transmit/Receive DMA Bus Arbiter

This block shares one bus master port between a transmit DMA requester and a receive DMA requester. Each transfer follows a simple handshake. A channel raises its request. The arbiter grants one channel, and the grant stays until the bus returns either a completion or an error for that transfer. The arbiter never takes the bus away in the middle of a transfer.

A mode input selects how contention is resolved. In weighted round-robin mode, a 2-bit weight sets how many receive grants are given for each transmit grant while both channels want the bus. In fixed mode, receive always wins. An error response halts the channel that owned the bus and sets a sticky fatal flag. It also records which channel failed and what kind of access it was. A halted channel stays out of arbitration until a synchronous soft reset or the asynchronous hard reset.

Top module: `dma_bus_arb`

## Requirements
- R1: At most one grant is high at any time. After reset, or after a transfer ends with no competitor eligible, a lone eligible requester is granted at the next clock edge.
- R2: A grant stays high, with no change of owner, until `xfer_done_i` or `xfer_err_i` is seen at a clock edge. When a transfer ends, the next owner is chosen at that same edge.
- R3: With `fixed_prio_i`=0 and weight w, while both channels are eligible at every decision, grants repeat the pattern of w+1 receive grants followed by one transmit grant. Receive goes first from a cleared counter.
- R4: Any decision at which the two channels are not both eligible clears the weight counter. The next contended run therefore starts with a full w+1 receive grants.
- R5: With `fixed_prio_i`=1, a decision with both channels eligible always grants receive.
- R6: An error response (`xfer_err_i`=1, which takes precedence over done) halts the owning channel. The grant is passed at that same edge, and only the other channel can receive it.
- R7: A halted channel's request is ignored. It is never granted until a soft or hard reset.
- R8: The first error sets `fatal_err_o`=1 and latches `err_rx_o` (0 = transmit, 1 = receive). It also latches `err_desc_o` (1 = descriptor access, 0 = data) and `err_wr_o` (1 = write, 0 = read), taken from the owner's attribute inputs. All four hold unchanged through later errors.
- R9: `soft_rst_i`=1 at a clock edge clears both halts, the fatal flag and the error record, any grant and the weight counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| soft_rst_i | input | 1 | Synchronous clear of grants, halts, status and counter |
| fixed_prio_i | input | 1 | 1 = receive always wins, 0 = weighted round-robin |
| weight_i | input | 2 | Receive grants per transmit grant, minus one |
| tx_req_i | input | 1 | Transmit channel request |
| tx_desc_i | input | 1 | Transmit access is a descriptor access |
| tx_wr_i | input | 1 | Transmit access is a write |
| rx_req_i | input | 1 | Receive channel request |
| rx_desc_i | input | 1 | Receive access is a descriptor access |
| rx_wr_i | input | 1 | Receive access is a write |
| xfer_done_i | input | 1 | Current transfer completed |
| xfer_err_i | input | 1 | Current transfer got an error response |
| tx_gnt_o | output | 1 | Bus granted to transmit |
| rx_gnt_o | output | 1 | Bus granted to receive |
| tx_halt_o | output | 1 | Transmit channel halted by an error |
| rx_halt_o | output | 1 | Receive channel halted by an error |
| fatal_err_o | output | 1 | Sticky fatal bus error flag |
| err_rx_o | output | 1 | Failing channel of first error |
| err_desc_o | output | 1 | First error was on a descriptor access |
| err_wr_o | output | 1 | First error was on a write |

## Verification
An error response and the re-arbitration it causes happen at the same clock edge. The failing channel is halted at that edge, and the grant moves on without that channel taking part. The bench provokes this by putting an error on a receive transfer while transmit is also requesting. At the next sample it expects the transmit grant, the receive halt and the error record together. It then holds the receive request high across further decisions and checks that no receive grant appears.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int unsigned NCH   = 2;
  localparam int unsigned CH_TX = 0;
  localparam int unsigned CH_RX = 1;

  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_TX   = 2'd1,
    OWN_RX   = 2'd2
  } owner_e;

  typedef struct packed {
    logic valid;
    logic ch;
    logic desc;
    logic wr;
  } err_rec_t;

  function automatic logic owns(owner_e o, int unsigned ch);
    return (ch == CH_TX) ? (o == OWN_TX) : (o == OWN_RX);
  endfunction
endpackage

// File: rtl/arb_wrr_pick.sv
module arb_wrr_pick
  import dma_arb_pkg::*;
#(
  parameter int unsigned WGT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             decide_i,
  input  logic             tx_ok_i,
  input  logic             rx_ok_i,
  input  logic             fixed_i,
  input  logic [WGT_W-1:0] weight_i,
  output owner_e           pick_o
);
  localparam int unsigned CNT_W = WGT_W + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d, limit;
  logic             both;

  assign both  = tx_ok_i & rx_ok_i;
  assign limit = {1'b0, weight_i} + CNT_W'(1);

  always_comb begin
    if (both) begin
      if (fixed_i || (cnt_q < limit)) pick_o = OWN_RX;
      else                            pick_o = OWN_TX;
    end else if (rx_ok_i) begin
      pick_o = OWN_RX;
    end else if (tx_ok_i) begin
      pick_o = OWN_TX;
    end else begin
      pick_o = OWN_NONE;
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    if (decide_i) begin
      if (both && !fixed_i) cnt_d = (cnt_q < limit) ? cnt_q + CNT_W'(1) : '0;
      else                  cnt_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= cnt_d;
  end

  // R1
  pick_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_ok_i || rx_ok_i) |-> (pick_o != OWN_NONE));
endmodule

// File: rtl/arb_grant_ctl.sv
module arb_grant_ctl
  import dma_arb_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   clr_i,
  input  logic   done_i,
  input  logic   err_i,
  input  owner_e pick_i,
  output owner_e owner_o,
  output logic   decide_o
);
  owner_e owner_q;

  assign decide_o = (owner_q == OWN_NONE) | done_i | err_i;
  assign owner_o  = owner_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       owner_q <= OWN_NONE;
    else if (clr_i)    owner_q <= OWN_NONE;
    else if (decide_o) owner_q <= pick_i;
  end

  // R2
  hold_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_q != OWN_NONE && !done_i && !err_i && !clr_i) |=> (owner_q == $past(owner_q)));
endmodule

// File: rtl/arb_err_latch.sv
module arb_err_latch
  import dma_arb_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clr_i,
  input  logic           err_i,
  input  owner_e         owner_i,
  input  logic [NCH-1:0] desc_i,
  input  logic [NCH-1:0] wr_i,
  output logic [NCH-1:0] halt_o,
  output err_rec_t       rec_o
);
  err_rec_t rec_q;
  logic     hit;

  assign hit = err_i & (owner_i != OWN_NONE);

  for (genvar c = 0; c < NCH; c++) begin : g_halt
    logic halt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    halt_q <= 1'b0;
      else if (clr_i)                 halt_q <= 1'b0;
      else if (err_i && owns(owner_i, c)) halt_q <= 1'b1;
    end
    assign halt_o[c] = halt_q;

    // R6
    halt_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (err_i && owns(owner_i, c) && !clr_i) |=> halt_o[c]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 rec_q <= '0;
    else if (clr_i)              rec_q <= '0;
    else if (hit && !rec_q.valid) begin
      rec_q.valid <= 1'b1;
      rec_q.ch    <= (owner_i == OWN_RX);
      rec_q.desc  <= (owner_i == OWN_RX) ? desc_i[CH_RX] : desc_i[CH_TX];
      rec_q.wr    <= (owner_i == OWN_RX) ? wr_i[CH_RX]   : wr_i[CH_TX];
    end
  end

  assign rec_o = rec_q;

  // R8
  rec_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_q.valid && !clr_i) |=> (rec_q.valid && $stable(rec_q)));
endmodule

// File: rtl/dma_bus_arb.sv
module dma_bus_arb
  import dma_arb_pkg::*;
#(
  parameter int unsigned WGT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             soft_rst_i,
  input  logic             fixed_prio_i,
  input  logic [WGT_W-1:0] weight_i,
  input  logic             tx_req_i,
  input  logic             tx_desc_i,
  input  logic             tx_wr_i,
  input  logic             rx_req_i,
  input  logic             rx_desc_i,
  input  logic             rx_wr_i,
  input  logic             xfer_done_i,
  input  logic             xfer_err_i,
  output logic             tx_gnt_o,
  output logic             rx_gnt_o,
  output logic             tx_halt_o,
  output logic             rx_halt_o,
  output logic             fatal_err_o,
  output logic             err_rx_o,
  output logic             err_desc_o,
  output logic             err_wr_o
);
  owner_e         owner, pick;
  logic           decide;
  logic [NCH-1:0] halt, req, ok, desc, wr;
  err_rec_t       rec;

  assign req  = {rx_req_i, tx_req_i};
  assign desc = {rx_desc_i, tx_desc_i};
  assign wr   = {rx_wr_i, tx_wr_i};

  // a channel failing right now drops out of the decision made at this edge
  for (genvar c = 0; c < NCH; c++) begin : g_ok
    assign ok[c] = req[c] & ~halt[c] & ~(xfer_err_i & owns(owner, c));
  end

  arb_wrr_pick #(.WGT_W(WGT_W)) u_pick (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (soft_rst_i),
    .decide_i (decide),
    .tx_ok_i  (ok[CH_TX]),
    .rx_ok_i  (ok[CH_RX]),
    .fixed_i  (fixed_prio_i),
    .weight_i (weight_i),
    .pick_o   (pick)
  );

  arb_grant_ctl u_gnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (soft_rst_i),
    .done_i   (xfer_done_i),
    .err_i    (xfer_err_i),
    .pick_i   (pick),
    .owner_o  (owner),
    .decide_o (decide)
  );

  arb_err_latch u_err (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (soft_rst_i),
    .err_i   (xfer_err_i),
    .owner_i (owner),
    .desc_i  (desc),
    .wr_i    (wr),
    .halt_o  (halt),
    .rec_o   (rec)
  );

  assign tx_gnt_o    = (owner == OWN_TX);
  assign rx_gnt_o    = (owner == OWN_RX);
  assign tx_halt_o   = halt[CH_TX];
  assign rx_halt_o   = halt[CH_RX];
  assign fatal_err_o = rec.valid;
  assign err_rx_o    = rec.ch;
  assign err_desc_o  = rec.desc;
  assign err_wr_o    = rec.wr;

  // R1
  one_gnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({tx_gnt_o, rx_gnt_o}));

  // R7
  tx_halt_no_gnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_halt_o |-> !tx_gnt_o);

  // R7
  rx_halt_no_gnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_halt_o |-> !rx_gnt_o);

  // R5
  fixed_rx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (decide && fixed_prio_i && ok[CH_TX] && ok[CH_RX] && !soft_rst_i) |=> rx_gnt_o);

  // R1
  lone_tx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (decide && ok[CH_TX] && !ok[CH_RX] && !soft_rst_i) |=> tx_gnt_o);

  // R9
  soft_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (!tx_gnt_o && !rx_gnt_o && !fatal_err_o && !tx_halt_o && !rx_halt_o));
endmodule

// File: tb/dma_bus_arb_tb_top.sv
module dma_bus_arb_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst = 0, fixed = 0, tx_req = 0, tx_desc = 0, tx_wr = 0;
  logic rx_req = 0, rx_desc = 0, rx_wr = 0, done = 0, err = 0;
  logic [1:0] weight = 2'd0;
  logic tx_gnt, rx_gnt, tx_halt, rx_halt, fatal, err_rx, err_desc, err_wr;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dma_bus_arb dut_i (
    .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst), .fixed_prio_i(fixed),
    .weight_i(weight), .tx_req_i(tx_req), .tx_desc_i(tx_desc), .tx_wr_i(tx_wr),
    .rx_req_i(rx_req), .rx_desc_i(rx_desc), .rx_wr_i(rx_wr),
    .xfer_done_i(done), .xfer_err_i(err), .tx_gnt_o(tx_gnt), .rx_gnt_o(rx_gnt),
    .tx_halt_o(tx_halt), .rx_halt_o(rx_halt), .fatal_err_o(fatal),
    .err_rx_o(err_rx), .err_desc_o(err_desc), .err_wr_o(err_wr)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle_out();
    tx_req = 0; rx_req = 0; done = 1; err = 0;
    tick();
    done = 0;
    tick();
  endtask

  task automatic t_reset();
    chk("R1 reset", {2'b0, tx_gnt, rx_gnt, tx_halt, rx_halt, fatal, err_rx}, 8'h00);
  endtask

  task automatic t_lone();
    tx_req = 1; tick();
    chk("R1 lone tx", {tx_gnt, rx_gnt}, 8'h2);
    rx_req = 1; tick();
    chk("R2 hold 1", {tx_gnt, rx_gnt}, 8'h2);
    tick();
    chk("R2 hold 2", {tx_gnt, rx_gnt}, 8'h2);
    done = 1; tx_req = 0; tick();
    chk("R1 handoff rx", {tx_gnt, rx_gnt}, 8'h1);
    rx_req = 0; tick();
    chk("R1 release", {tx_gnt, rx_gnt}, 8'h0);
    done = 0; tick();
  endtask

  task automatic t_wrr(int w, int n);
    weight = w[1:0]; fixed = 0; tx_req = 1; rx_req = 1; done = 0;
    tick();
    for (int k = 0; k < n; k++) begin
      logic e_rx;
      e_rx = ((k % (w + 2)) < (w + 1));
      chk($sformatf("R3 w=%0d k=%0d", w, k), {tx_gnt, rx_gnt}, e_rx ? 8'h1 : 8'h2);
      done = 1; tick();
    end
    idle_out();
  endtask

  task automatic t_contention();
    weight = 2'd3; fixed = 0; tx_req = 1; rx_req = 1; done = 0;
    tick();
    chk("R4 pre 1", {tx_gnt, rx_gnt}, 8'h1);
    done = 1; tick();
    chk("R4 pre 2", {tx_gnt, rx_gnt}, 8'h1);
    tx_req = 0; tick();
    chk("R4 lone", {tx_gnt, rx_gnt}, 8'h1);
    tx_req = 1; tick();
    for (int k = 0; k < 5; k++) begin
      chk($sformatf("R4 run k=%0d", k), {tx_gnt, rx_gnt}, (k < 4) ? 8'h1 : 8'h2);
      tick();
    end
    idle_out();
  endtask

  task automatic t_fixed();
    fixed = 1; weight = 2'd0; tx_req = 1; rx_req = 1; done = 0;
    tick();
    for (int k = 0; k < 4; k++) begin
      chk($sformatf("R5 k=%0d", k), {tx_gnt, rx_gnt}, 8'h1);
      done = 1; tick();
    end
    rx_req = 0; tick();
    chk("R5 tx alone", {tx_gnt, rx_gnt}, 8'h2);
    idle_out();
    fixed = 0;
  endtask

  task automatic t_error();
    weight = 2'd0; tx_req = 1; rx_req = 1; done = 0;
    tick();
    chk("R6 rx owns", {tx_gnt, rx_gnt}, 8'h1);
    rx_desc = 1; rx_wr = 0; tx_desc = 0; tx_wr = 1; err = 1; tick();
    err = 0;
    chk("R6 pass to tx", {tx_gnt, rx_gnt, rx_halt, tx_halt}, 8'h8 >> 0 | 8'h2);
    chk("R8 record", {fatal, err_rx, err_desc, err_wr}, 8'hE);
    done = 1; tx_req = 0; tick();
    chk("R7 rx ignored 1", {tx_gnt, rx_gnt}, 8'h0);
    done = 0; tick();
    chk("R7 rx ignored 2", {tx_gnt, rx_gnt}, 8'h0);
    tx_req = 1; tick();
    chk("R7 tx lone", {tx_gnt, rx_gnt}, 8'h2);
    err = 1; tick();
    err = 0;
    chk("R6 tx halted", {tx_gnt, rx_gnt, tx_halt, rx_halt}, 8'h3);
    chk("R8 first kept", {fatal, err_rx, err_desc, err_wr}, 8'hE);
    tick();
  endtask

  task automatic t_soft();
    soft_rst = 1; tick();
    soft_rst = 0;
    chk("R9 cleared", {tx_gnt, rx_gnt, tx_halt, rx_halt, fatal, err_rx, err_desc, err_wr}, 8'h00);
    tick();
    chk("R9 rx resumes", {tx_gnt, rx_gnt}, 8'h1);
    idle_out();
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    t_reset();
    t_lone();
    t_wrr(0, 6);
    t_wrr(1, 6);
    t_wrr(3, 10);
    t_contention();
    t_fixed();
    t_error();
    t_soft();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule